// File: doc/BRIEF.md
# Dual-Master Banked Memory Arbiter

This block lets two processor ports share one memory region built from several single-port banks. Every cycle each port may present a request with a word address, a write enable, write data and a space tag that marks the access as data space or program space. The block decodes the target bank of each request. Requests that land in different banks are served together. Requests that land in the same bank are settled by a policy chosen at run time, and the port that loses sees its wait output high until its turn comes.

Data-space accesses finish in the cycle they are granted. Program-space accesses need one extra cycle, and the bank stays reserved for that port during the extra cycle. Read data appears on the port in the cycle its access finishes. The banks are behavioural arrays that keep only the low word bits of each bank, so the full decoded address range is exercised with small storage.

Top module: `shm_dual_arbiter`

## Requirements
- R1: A request address A is inside the region when BASE <= A < BASE + NUM_BANKS * 2^BANK_AW (0x030000 to 0x037FFF by default). The bank index is bits [BANK_AW+1:BANK_AW] of A - BASE (bits [14:13] by default), and the low STORE_AW bits of A - BASE pick the stored word. A request outside the region keeps wait low, returns read data zero and writes nothing.
- R2: Two requests to different banks in the same cycle are both granted in that cycle, with neither port waiting.
- R3: A granted data-space access (space tag 0) completes in its request cycle with wait low. A granted program-space access (space tag 1) drives wait high in its first granted cycle and completes in the following cycle, while its request is held.
- R4: In the cycle a read completes, read data equals the word last written at that location. In every other cycle (idle, waiting, writing or outside the region) read data is zero. A write is stored at the clock edge that ends its completing cycle.
- R5: A bank serves at most one access per cycle. The port that is not served drives wait high, holds its request, and completes once it is granted.
- R6: The 2-bit policy code selects the winner of a same-bank conflict: 00 and 11 mean round-robin, 01 means port 0 always wins, and 10 means port 1 always wins.
- R7: Round-robin priority is kept separately for each bank. After reset, port 0 wins the first conflict on every bank. Each conflict on a bank hands the next conflict on that bank to the port that lost, and leaves the other banks unchanged.
- R8: A program-space access in its second cycle keeps its bank. The other port waits on that bank whatever the policy is.
- R9: The policy code is sampled at a clock edge only when no program-space access is in its second cycle. A sampled code takes effect from the next cycle.
- R10: After reset the policy is round-robin, and a port with its request low has wait low and read data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_policy | input | 2 | Conflict policy code (see R6) |
| m0_req | input | 1 | Port 0 request valid |
| m0_addr | input | ADDR_W | Port 0 word address |
| m0_we | input | 1 | Port 0 write enable |
| m0_wdata | input | DATA_W | Port 0 write data |
| m0_pspace | input | 1 | Port 0 space tag: 0 data, 1 program |
| m0_wait | output | 1 | Port 0 stall; request must be held while high |
| m0_rdata | output | DATA_W | Port 0 read data, valid in the completing cycle |
| m1_req | input | 1 | Port 1 request valid |
| m1_addr | input | ADDR_W | Port 1 word address |
| m1_we | input | 1 | Port 1 write enable |
| m1_wdata | input | DATA_W | Port 1 write data |
| m1_pspace | input | 1 | Port 1 space tag: 0 data, 1 program |
| m1_wait | output | 1 | Port 1 stall; request must be held while high |
| m1_rdata | output | DATA_W | Port 1 read data, valid in the completing cycle |

## Verification
The bench uses the default parameters: 24-bit words and addresses, base 0x030000, four banks selected by offset bits [14:13], and 256 stored words per bank. With these values the top word of the region (0x037FFF) and the first word past it (0x038000) can be reached. The out-of-range word 0x038000 would alias to bank 0, word 0 if the range check were missing. Conflicts can be placed on chosen banks, so the round-robin state of one bank can be shown to stay separate from another. All four policy codes are used, and a policy change is applied during a program-space hold to show that the sampling is deferred.

// File: rtl/shm_pkg.sv
package shm_pkg;

   // Conflict policy codes; the two round-robin codes behave alike.
   typedef enum logic [1:0] {
      POL_RR     = 2'b00,
      POL_M0     = 2'b01,
      POL_M1     = 2'b10,
      POL_RR_ALT = 2'b11
   } pol_e;

   localparam int NUM_PORTS = 2;

endpackage

// File: rtl/shm_decode.sv
module shm_decode #(
   parameter int ADDR_W    = 24,
   parameter int NUM_BANKS = 4,
   parameter int BANK_AW   = 13,
   parameter int STORE_AW  = 8,
   parameter logic [ADDR_W-1:0] BASE = 'h030000
) (
   input  logic                         req,
   input  logic [ADDR_W-1:0]            addr,
   output logic                         hit,
   output logic [$clog2(NUM_BANKS)-1:0] bank,
   output logic [STORE_AW-1:0]          word
);
   localparam int BANK_BITS = $clog2(NUM_BANKS);
   localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(NUM_BANKS) << BANK_AW;

   logic [ADDR_W-1:0] off;

   assign off  = addr - BASE;
   // The lower bound catches the wrap-around of off for addresses below BASE.
   assign hit  = req && (addr >= BASE) && ({1'b0, off} < SPAN);
   assign bank = off[BANK_AW +: BANK_BITS];
   assign word = off[STORE_AW-1:0];

endmodule

// File: rtl/shm_bank_arb.sv
module shm_bank_arb
   import shm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pol_e       pol,
   input  logic [1:0] want,
   input  logic [1:0] hold,
   output logic [1:0] gnt
);
   logic pri_q;   // port that wins the next conflict in round-robin
   logic win;
   logic clash;

   always_comb begin
      clash = (want == 2'b11) && (hold == 2'b00);
      unique case (pol)
         POL_M0:  win = 1'b0;
         POL_M1:  win = 1'b1;
         default: win = pri_q;
      endcase
      if (hold[0])      gnt = 2'b01;
      else if (hold[1]) gnt = 2'b10;
      else if (clash)   gnt = win ? 2'b10 : 2'b01;
      else              gnt = want;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pri_q <= 1'b0;
      else if (clash) pri_q <= ~win;
   end

endmodule

// File: rtl/shm_bank_mem.sv
module shm_bank_mem #(
   parameter int DATA_W   = 24,
   parameter int STORE_AW = 8
) (
   input  logic                clk,
   input  logic                wr_en,
   input  logic [STORE_AW-1:0] word,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata
);
   localparam int DEPTH = 1 << STORE_AW;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[word] <= wdata;
   end

   assign rdata = cells[word];

endmodule

// File: rtl/shm_dual_arbiter.sv
module shm_dual_arbiter
   import shm_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 24,
   parameter int NUM_BANKS = 4,
   parameter int BANK_AW   = 13,
   parameter int STORE_AW  = 8,
   parameter logic [ADDR_W-1:0] BASE = 'h030000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_policy,
   input  logic              m0_req,
   input  logic [ADDR_W-1:0] m0_addr,
   input  logic              m0_we,
   input  logic [DATA_W-1:0] m0_wdata,
   input  logic              m0_pspace,
   output logic              m0_wait,
   output logic [DATA_W-1:0] m0_rdata,
   input  logic              m1_req,
   input  logic [ADDR_W-1:0] m1_addr,
   input  logic              m1_we,
   input  logic [DATA_W-1:0] m1_wdata,
   input  logic              m1_pspace,
   output logic              m1_wait,
   output logic [DATA_W-1:0] m1_rdata
);
   localparam int    BANK_BITS = $clog2(NUM_BANKS);
   localparam int    NP        = NUM_PORTS;
   localparam longint SPAN_W   = longint'(NUM_BANKS) << BANK_AW;

   // Elaboration-time parameter checks
   if (NUM_BANKS < 2 || (1 << BANK_BITS) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (STORE_AW < 1 || STORE_AW > BANK_AW) begin : g_bad_store
      $error("STORE_AW must lie between 1 and BANK_AW");
   end
   if ((longint'(BASE) % SPAN_W) != 0 ||
       (longint'(BASE) + SPAN_W) > (longint'(1) << ADDR_W)) begin : g_bad_base
      $error("BASE must be aligned to the region and the region must fit the address space");
   end

   // Per-port vectors
   logic [NP-1:0]        req_v, we_v, ps_v, hit_v, done_v, ph_q, ph_d;
   logic [ADDR_W-1:0]    addr_v [NP];
   logic [DATA_W-1:0]    wd_v   [NP];
   logic [DATA_W-1:0]    rd_v   [NP];
   logic [BANK_BITS-1:0] bank_v [NP];
   logic [STORE_AW-1:0]  word_v [NP];

   logic [NUM_BANKS-1:0][NP-1:0]     gnt_all;
   logic [NUM_BANKS-1:0][DATA_W-1:0] brd;

   pol_e pol_q;

   assign req_v     = {m1_req, m0_req};
   assign we_v      = {m1_we, m0_we};
   assign ps_v      = {m1_pspace, m0_pspace};
   assign addr_v[0] = m0_addr;
   assign addr_v[1] = m1_addr;
   assign wd_v[0]   = m0_wdata;
   assign wd_v[1]   = m1_wdata;

   for (genvar m = 0; m < NP; m++) begin : g_port
      shm_decode #(
         .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW),
         .STORE_AW(STORE_AW), .BASE(BASE)
      ) u_dec (
         .req  (req_v[m]),
         .addr (addr_v[m]),
         .hit  (hit_v[m]),
         .bank (bank_v[m]),
         .word (word_v[m])
      );
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [NP-1:0]       want, gnt;
      logic                sel, wr;
      logic [STORE_AW-1:0] word;
      logic [DATA_W-1:0]   wdata;

      always_comb begin
         for (int m = 0; m < NP; m++)
            want[m] = hit_v[m] && (bank_v[m] == BANK_BITS'(b));
      end

      shm_bank_arb u_arb (
         .clk   (clk),
         .rst_n (rst_n),
         .pol   (pol_q),
         .want  (want),
         .hold  (want & ph_q),
         .gnt   (gnt)
      );

      assign sel   = gnt[1];
      assign wr    = |(gnt & done_v & we_v);
      assign word  = sel ? word_v[1] : word_v[0];
      assign wdata = sel ? wd_v[1]   : wd_v[0];
      assign gnt_all[b] = gnt;

      shm_bank_mem #(.DATA_W(DATA_W), .STORE_AW(STORE_AW)) u_mem (
         .clk   (clk),
         .wr_en (wr),
         .word  (word),
         .wdata (wdata),
         .rdata (brd[b])
      );
   end

   // Grant gathering, completion and program-space phase
   always_comb begin
      for (int m = 0; m < NP; m++) begin
         logic granted;
         granted = 1'b0;
         for (int b = 0; b < NUM_BANKS; b++) granted = granted | gnt_all[b][m];
         done_v[m] = granted && (!ps_v[m] || ph_q[m]);
         ph_d[m]   = granted && ps_v[m] && !ph_q[m];
      end
   end

   always_comb begin
      for (int m = 0; m < NP; m++)
         rd_v[m] = (done_v[m] && !we_v[m]) ? brd[bank_v[m]] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         pol_q <= POL_RR;
      end else begin
         ph_q <= ph_d;
         if (ph_q == '0) pol_q <= pol_e'(cfg_policy);
      end
   end

   assign m0_wait  = hit_v[0] && !done_v[0];
   assign m1_wait  = hit_v[1] && !done_v[1];
   assign m0_rdata = rd_v[0];
   assign m1_rdata = rd_v[1];

endmodule

// File: rtl/shm_dual_arbiter_chk.sv
module shm_dual_arbiter_chk #(
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 24,
   parameter int NUM_BANKS = 4,
   parameter int BANK_AW   = 13,
   parameter logic [ADDR_W-1:0] BASE = 'h030000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m0_req,
   input logic [ADDR_W-1:0] m0_addr,
   input logic              m0_pspace,
   input logic              m0_wait,
   input logic [DATA_W-1:0] m0_rdata,
   input logic              m1_req,
   input logic [ADDR_W-1:0] m1_addr,
   input logic              m1_pspace,
   input logic              m1_wait,
   input logic [DATA_W-1:0] m1_rdata,
   input logic [1:0]        pol_q,
   input logic [1:0]        ph_q
);
   localparam longint SPAN = longint'(NUM_BANKS) << BANK_AW;

   function automatic logic in_rgn(input logic [ADDR_W-1:0] a);
      return (longint'(a) >= longint'(BASE)) && (longint'(a) < longint'(BASE) + SPAN);
   endfunction

   function automatic longint bank_of(input logic [ADDR_W-1:0] a);
      return ((longint'(a) - longint'(BASE)) >> BANK_AW) % NUM_BANKS;
   endfunction

   logic v0, v1, same;
   assign v0   = m0_req && in_rgn(m0_addr);
   assign v1   = m1_req && in_rgn(m1_addr);
   assign same = v0 && v1 && (bank_of(m0_addr) == bank_of(m1_addr));

   assert_outside0_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (m0_req && !in_rgn(m0_addr)) |-> (!m0_wait && m0_rdata == '0));
   assert_outside1_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (m1_req && !in_rgn(m1_addr)) |-> (!m1_wait && m1_rdata == '0));

   assert_diff_banks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (v0 && v1 && !same && !m0_pspace && !m1_pspace) |-> (!m0_wait && !m1_wait));

   assert_prog_wait0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (v0 && m0_pspace && !m0_wait) |-> $past(m0_wait));
   assert_prog_wait1_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (v1 && m1_pspace && !m1_wait) |-> $past(m1_wait));

   assert_rdata_quiet0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!m0_req || m0_wait) |-> (m0_rdata == '0));
   assert_rdata_quiet1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!m1_req || m1_wait) |-> (m1_rdata == '0));

   assert_one_per_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      same |-> (m0_wait || m1_wait));

   assert_fixed_m0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_q == 2'b01 && same && ph_q == 2'b00) |-> (m1_wait && (m0_pspace || !m0_wait)));
   assert_fixed_m1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_q == 2'b10 && same && ph_q == 2'b00) |-> (m0_wait && (m1_pspace || !m1_wait)));

   assert_hold0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q[0] && same) |-> m1_wait);
   assert_hold1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q[1] && same) |-> m0_wait);

   assert_policy_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != 2'b00) |=> (pol_q == $past(pol_q)));

endmodule

bind shm_dual_arbiter shm_dual_arbiter_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS),
   .BANK_AW(BANK_AW), .BASE(BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .m0_req    (m0_req),
   .m0_addr   (m0_addr),
   .m0_pspace (m0_pspace),
   .m0_wait   (m0_wait),
   .m0_rdata  (m0_rdata),
   .m1_req    (m1_req),
   .m1_addr   (m1_addr),
   .m1_pspace (m1_pspace),
   .m1_wait   (m1_wait),
   .m1_rdata  (m1_rdata),
   .pol_q     (pol_q),
   .ph_q      (ph_q)
);

// File: tb/shm_dual_arbiter_test.sv
`timescale 1ns/1ps
module shm_dual_arbiter_test;
   localparam logic [23:0] BASE = 24'h030000;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic        rst_n;
   logic [1:0]  cfg_policy;
   logic        m0_req, m0_we, m0_pspace, m0_wait;
   logic        m1_req, m1_we, m1_pspace, m1_wait;
   logic [23:0] m0_addr, m0_wdata, m0_rdata;
   logic [23:0] m1_addr, m1_wdata, m1_rdata;

   shm_dual_arbiter uut (
      .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy),
      .m0_req(m0_req), .m0_addr(m0_addr), .m0_we(m0_we), .m0_wdata(m0_wdata),
      .m0_pspace(m0_pspace), .m0_wait(m0_wait), .m0_rdata(m0_rdata),
      .m1_req(m1_req), .m1_addr(m1_addr), .m1_we(m1_we), .m1_wdata(m1_wdata),
      .m1_pspace(m1_pspace), .m1_wait(m1_wait), .m1_rdata(m1_rdata)
   );

   typedef struct { logic req; logic [23:0] addr; logic we; logic [23:0] d; logic ps; } rq_t;
   typedef struct { logic w0; logic w1; logic [23:0] r0; logic [23:0] r1; string tag; } exp_t;

   exp_t       sb[$];
   int         tests = 0;
   int         fails = 0;
   logic [1:0] pol_next = 2'b00;

   function automatic logic [23:0] A(input int b, input int w);
      return BASE + 24'(b * 'h2000 + w);
   endfunction
   function automatic rq_t IDLE();
      rq_t r; r.req = 0; r.addr = '0; r.we = 0; r.d = '0; r.ps = 0; return r;
   endfunction
   function automatic rq_t RD(input logic [23:0] a);
      rq_t r; r = IDLE(); r.req = 1; r.addr = a; return r;
   endfunction
   function automatic rq_t PRD(input logic [23:0] a);
      rq_t r; r = RD(a); r.ps = 1; return r;
   endfunction
   function automatic rq_t WR(input logic [23:0] a, input logic [23:0] d);
      rq_t r; r = RD(a); r.we = 1; r.d = d; return r;
   endfunction

   task automatic drive(input rq_t r0, input rq_t r1);
      m0_req = r0.req; m0_addr = r0.addr; m0_we = r0.we; m0_wdata = r0.d; m0_pspace = r0.ps;
      m1_req = r1.req; m1_addr = r1.addr; m1_we = r1.we; m1_wdata = r1.d; m1_pspace = r1.ps;
   endtask

   // Driver: one cycle of stimulus plus its expected result into the scoreboard
   task automatic step(input rq_t r0, input rq_t r1, input logic ew0, input logic ew1,
                       input logic [23:0] er0, input logic [23:0] er1, input string tag);
      exp_t e;
      @(negedge clk);
      cfg_policy = pol_next;
      drive(r0, r1);
      e.w0 = ew0; e.w1 = ew1; e.r0 = er0; e.r1 = er1; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic chk(input string tag, input string what, input logic [23:0] act,
                      input logic [23:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Monitor: compares outputs one time unit after the driving edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "m0_wait",  24'(m0_wait), 24'(e.w0));
            chk(e.tag, "m1_wait",  24'(m1_wait), 24'(e.w1));
            chk(e.tag, "m0_rdata", m0_rdata, e.r0);
            chk(e.tag, "m1_rdata", m1_rdata, e.r1);
         end
      end
   end

   initial begin
      #(200000 * 4);
      tests++;
      fails++;
      $display("FAIL watchdog (all requirements): actual still running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cfg_policy = 2'b00;
      drive(IDLE(), IDLE());
      repeat (2) @(negedge clk);
      #1;
      chk("R10 in reset", "m0_wait", 24'(m0_wait), 24'h0);
      chk("R10 in reset", "m1_rdata", m1_rdata, 24'h0);
      @(negedge clk);
      rst_n = 1'b1;

      step(IDLE(), IDLE(), 0, 0, 0, 0, "R10 idle after reset");
      // R2 different banks
      step(WR(A(0,5), 24'hAAAA01), WR(A(1,7), 24'h555502), 0, 0, 0, 0, "R2 writes to two banks");
      step(RD(A(1,7)), RD(A(0,5)), 0, 0, 24'h555502, 24'hAAAA01, "R2 R4 reads from two banks");
      // R7 round-robin from reset, R5 loser holds
      step(WR(A(2,3), 24'h111111), WR(A(2,4), 24'h222222), 0, 1, 0, 0, "R7 first conflict port 0");
      step(IDLE(), WR(A(2,4), 24'h222222), 0, 0, 0, 0, "R5 held loser completes");
      step(RD(A(2,4)), RD(A(2,3)), 1, 0, 0, 24'h111111, "R7 last loser wins");
      step(RD(A(2,4)), IDLE(), 0, 0, 24'h222222, 0, "R5 R4 port 0 completes later");
      step(WR(A(3,9), 24'h333333), WR(A(3,10), 24'h444444), 0, 1, 0, 0, "R7 bank 3 priority separate");
      step(IDLE(), WR(A(3,10), 24'h444444), 0, 0, 0, 0, "R5 bank 3 loser completes");
      // R6 port 1 fixed priority
      pol_next = 2'b10;
      step(IDLE(), IDLE(), 0, 0, 0, 0, "R9 policy sampled while idle");
      step(RD(A(0,5)), RD(A(0,5)), 1, 0, 0, 24'hAAAA01, "R6 code 10 port 1 wins");
      step(RD(A(0,5)), WR(A(0,6), 24'h666666), 1, 0, 0, 0, "R6 code 10 port 1 wins again");
      step(RD(A(0,5)), IDLE(), 0, 0, 24'hAAAA01, 0, "R5 starved port completes");
      // R6 port 0 fixed priority
      pol_next = 2'b01;
      step(IDLE(), IDLE(), 0, 0, 0, 0, "R9 policy sampled while idle");
      step(WR(A(1,8), 24'h123456), RD(A(1,7)), 0, 1, 0, 0, "R6 code 01 port 0 wins");
      step(IDLE(), RD(A(1,7)), 0, 0, 0, 24'h555502, "R6 R5 port 1 completes");
      // R3 program space
      step(PRD(A(1,7)), IDLE(), 1, 0, 0, 0, "R3 program first cycle waits");
      step(PRD(A(1,7)), IDLE(), 0, 0, 24'h555502, 0, "R3 program completes second cycle");
      step(PRD(A(0,5)), RD(A(1,8)), 1, 0, 0, 24'h123456, "R2 R3 program and data on two banks");
      step(PRD(A(0,5)), IDLE(), 0, 0, 24'hAAAA01, 0, "R3 program completes");
      // R8 hold and R9 deferred sampling
      step(PRD(A(3,9)), RD(A(3,9)), 1, 1, 0, 0, "R6 port 0 wins program start");
      pol_next = 2'b10;
      step(PRD(A(3,9)), RD(A(3,9)), 0, 1, 24'h333333, 0, "R8 held bank blocks port 1");
      step(RD(A(3,10)), RD(A(3,9)), 0, 1, 24'h444444, 0, "R9 old policy kept during hold");
      step(RD(A(3,10)), RD(A(3,9)), 1, 0, 0, 24'h333333, "R9 new policy after hold");
      step(RD(A(3,10)), IDLE(), 0, 0, 24'h444444, 0, "R5 port 0 completes");
      // R1 region bounds
      pol_next = 2'b00;
      step(WR(A(0,0), 24'h0000AB), IDLE(), 0, 0, 0, 0, "R1 write bank 0 word 0");
      step(WR(24'h02FFFF, 24'h777777), WR(24'h038000, 24'h777777), 0, 0, 0, 0, "R1 outside writes no wait");
      step(RD(A(0,0)), PRD(24'h038000), 0, 0, 24'h0000AB, 0, "R1 outside write ignored");
      pol_next = 2'b11;
      step(WR(24'h037FFF, 24'hABCDEF), IDLE(), 0, 0, 0, 0, "R1 top word write");
      step(RD(24'h037FFF), IDLE(), 0, 0, 24'hABCDEF, 0, "R1 top word read");
      // R6 code 11 acts as round-robin (bank 2 priority back at port 0)
      step(RD(A(2,3)), RD(A(2,3)), 0, 1, 24'h111111, 0, "R6 code 11 round-robin port 0");
      step(RD(A(2,4)), RD(A(2,3)), 1, 0, 0, 24'h111111, "R6 R7 code 11 loser wins");
      step(RD(A(2,4)), IDLE(), 0, 0, 24'h222222, 0, "R5 port 0 completes");
      step(IDLE(), IDLE(), 0, 0, 0, 0, "R10 idle");

      @(negedge clk);
      #2;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule